// File: doc/BRIEF.md
# DES Round Subkey Scheduler

This block supplies a DES cipher core with its sixteen 48-bit round subkeys, one per clock, as the core asks for them. A 64-bit key is captured on a load pulse. The eight parity bits are discarded and the remaining 56 bits are split into two 28-bit halves. Each step pulse then moves the halves on by one round and presents the compressed 48-bit subkey for that round on a registered output, along with the round number.

Subkeys are never stored. Each one is produced on the fly by rotating the two halves in place. For encryption the halves rotate left by the per-round amount. For decryption the first subkey comes from the halves as loaded, and each later round rotates them right by the schedule read backwards. This hands the core the encryption subkeys in reverse order without a second pass. The direction is fixed at load time.

Top module: `des_subkey_sched`

## Requirements
- R1: After reset, `round_idx` is 0, `subkey_valid` is 0 and `subkey` is all zeros.
- R2: A cycle with `load` high captures `key` and `decrypt`, and after that edge `round_idx` is 0 and `subkey_valid` is 0. When `load` and `step` are both high, `load` wins and the round index stays 0.
- R3: A `step` while `round_idx` is below 16 and `load` is low advances `round_idx` by one. At the same edge it presents that round's subkey on `subkey` with `subkey_valid` high.
- R4: In encryption mode (`decrypt`=0 at load), the subkey for round r is formed in three steps. First the 56 non-parity key bits are reduced into halves C and D by the standard DES key-reduction permutation. Bit 1 is the key MSB `key[63]`. Next, each half is rotated left by the cumulative shift for rounds 1..r, where the shifts are 1 in rounds 1, 2, 9 and 16 and 2 in every other round. Finally, the 48 subkey bits are selected from {C,D} by the standard compression permutation, with subkey bit 1 on `subkey[47]`. Key 133457799BBCDFF1 gives round 1 = 1B02EFFC7072 and round 16 = CB3D8B0E17F5.
- R5: In decryption mode, the subkey for round r equals the encryption subkey for round 17-r of the same key.
- R6: The parity bits `key[56]`, `key[48]`, `key[40]`, `key[32]`, `key[24]`, `key[16]`, `key[8]` and `key[0]` have no effect on any subkey.
- R7: Once `round_idx` reaches 16, further `step` pulses change neither `round_idx` nor `subkey` until the next load.
- R8: With `load` and `step` both low, `round_idx`, `subkey` and `subkey_valid` hold their values.
- R9: A load in the middle of a sequence restarts it. The following steps produce rounds 1 onward for the newly loaded key.
- R10: Changes on `decrypt` between loads do not change the order of the subkey sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture key and mode, rewind to round 0 |
| key | input | 64 | Cipher key including parity bits |
| decrypt | input | 1 | Order select sampled at load: 0 forward, 1 reverse |
| step | input | 1 | Advance to the next round |
| subkey | output | 48 | Registered subkey for the current round |
| round_idx | output | 5 | Current round, 0 after load, 1 to 16 |
| subkey_valid | output | 1 | High while `subkey` holds a round subkey |

## Verification
The bench sweeps ten keys in both orders and compares every round against a reference that builds each round's halves from a cumulative rotation count. A design that rotates by the wrong amount in the 1-bit rounds, or that runs the reversed schedule off by one round, shows up as a mismatch from that round on. The two published subkeys pin the permutation tables: a wrong table entry or reversed bit numbering gives a wrong round 1. Flipping only the parity bits must leave all subkeys unchanged, which catches a reduction that keeps a parity bit. Extra steps after round 16, a restart in mid-sequence, a load that coincides with a step, and a mode change between loads catch designs that wrap the round counter, let step override load, or read the mode live.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;

  localparam int KEY_W   = 64;
  localparam int HALF_W  = 28;
  localparam int RED_W   = 2 * HALF_W;
  localparam int SUB_W   = 48;
  localparam int ROUNDS  = 16;
  localparam int RIDX_W  = $clog2(ROUNDS + 1);

  // key bit numbers (1 = MSB) feeding each reduced bit, C half first
  localparam byte unsigned REDUCE_MAP [RED_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
  };

  // reduced bit numbers (1 = MSB of {C,D}) feeding each subkey bit
  localparam byte unsigned COMPRESS_MAP [SUB_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  // left-rotation amount of round r (1..ROUNDS)
  function automatic logic [1:0] shift_of(input logic [RIDX_W-1:0] r);
    if (r == 0 || r > RIDX_W'(ROUNDS))
      return 2'd0;
    else if (r == 1 || r == 2 || r == 9 || r == RIDX_W'(ROUNDS))
      return 2'd1;
    else
      return 2'd2;
  endfunction

endpackage

// File: rtl/des_key_reduce.sv
module des_key_reduce
  import des_ks_pkg::*;
(
  input  logic [KEY_W-1:0]  key_i,
  output logic [HALF_W-1:0] c_o,
  output logic [HALF_W-1:0] d_o
);
  logic [RED_W-1:0] red;

  for (genvar j = 0; j < RED_W; j++) begin : g_sel
    assign red[RED_W-1-j] = key_i[KEY_W - int'(REDUCE_MAP[j])];
  end

  assign c_o = red[RED_W-1:HALF_W];
  assign d_o = red[HALF_W-1:0];
endmodule

// File: rtl/des_half_rotator.sv
module des_half_rotator #(
  parameter int W = 28
) (
  input  logic [W-1:0] data_i,
  input  logic [1:0]   amt_i,
  input  logic         right_i,
  output logic [W-1:0] data_o
);
  always_comb begin
    unique case ({right_i, amt_i})
      3'b001:  data_o = {data_i[W-2:0], data_i[W-1]};
      3'b010:  data_o = {data_i[W-3:0], data_i[W-1:W-2]};
      3'b101:  data_o = {data_i[0], data_i[W-1:1]};
      3'b110:  data_o = {data_i[1:0], data_i[W-1:2]};
      default: data_o = data_i;
    endcase
  end

  // a rotation never creates or loses ones (R4)
  always_comb begin
    if (!$isunknown(data_i))
      assert_rot_weight_R4: assert ($countones(data_o) == $countones(data_i));
  end
endmodule

// File: rtl/des_subkey_compress.sv
module des_subkey_compress
  import des_ks_pkg::*;
(
  input  logic [HALF_W-1:0] c_i,
  input  logic [HALF_W-1:0] d_i,
  output logic [SUB_W-1:0]  subkey_o
);
  logic [RED_W-1:0] cd;
  assign cd = {c_i, d_i};

  for (genvar j = 0; j < SUB_W; j++) begin : g_sel
    assign subkey_o[SUB_W-1-j] = cd[RED_W - int'(COMPRESS_MAP[j])];
  end
endmodule

// File: rtl/des_subkey_sched.sv
module des_subkey_sched
  import des_ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [KEY_W-1:0]  key,
  input  logic              decrypt,
  input  logic              step,
  output logic [SUB_W-1:0]  subkey,
  output logic [RIDX_W-1:0] round_idx,
  output logic              subkey_valid
);
  logic [HALF_W-1:0] half_q   [2];
  logic [HALF_W-1:0] half_rot [2];
  logic [HALF_W-1:0] load_c, load_d;
  logic              dec_q;
  logic [RIDX_W-1:0] round_q;
  logic [RIDX_W-1:0] next_round;
  logic [1:0]        amt;
  logic              go_right;
  logic              advance;
  logic [SUB_W-1:0]  subkey_next;

  des_key_reduce u_reduce (
    .key_i (key),
    .c_o   (load_c),
    .d_o   (load_d)
  );

  assign next_round = round_q + 1'b1;
  assign advance    = step && !load && (round_q < RIDX_W'(ROUNDS));

  // reverse order: round 1 is the loaded halves, round r undoes forward round 18-r
  always_comb begin
    if (dec_q) begin
      go_right = 1'b1;
      amt      = (next_round == 1) ? 2'd0
                                   : shift_of(RIDX_W'(ROUNDS + 2) - next_round);
    end else begin
      go_right = 1'b0;
      amt      = shift_of(next_round);
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    des_half_rotator #(.W(HALF_W)) u_rot (
      .data_i  (half_q[h]),
      .amt_i   (amt),
      .right_i (go_right),
      .data_o  (half_rot[h])
    );
  end

  des_subkey_compress u_compress (
    .c_i      (half_rot[0]),
    .d_i      (half_rot[1]),
    .subkey_o (subkey_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q[0]    <= '0;
      half_q[1]    <= '0;
      dec_q        <= 1'b0;
      round_q      <= '0;
      subkey       <= '0;
      subkey_valid <= 1'b0;
    end else if (load) begin
      half_q[0]    <= load_c;
      half_q[1]    <= load_d;
      dec_q        <= decrypt;
      round_q      <= '0;
      subkey_valid <= 1'b0;
    end else if (advance) begin
      half_q[0]    <= half_rot[0];
      half_q[1]    <= half_rot[1];
      round_q      <= next_round;
      subkey       <= subkey_next;
      subkey_valid <= 1'b1;
    end
  end

  assign round_idx = round_q;

  assert_round_bound_R3: assert property (@(posedge clk) disable iff (rst)
    round_idx <= RIDX_W'(ROUNDS));

  assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && round_idx < RIDX_W'(ROUNDS))
      |=> (round_idx == $past(round_idx) + 1'b1) && subkey_valid);

  assert_load_rewind_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (round_idx == '0) && !subkey_valid);

  assert_hold_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && round_idx == RIDX_W'(ROUNDS)) |=> $stable(round_idx) && $stable(subkey));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(subkey) && $stable(round_idx) && $stable(subkey_valid));

  assert_mode_latched_R10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dec_q));
endmodule

// File: tb/tb_des_subkey_sched.sv
module tb_des_subkey_sched;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst, load, decrypt, step;
  logic [63:0] key;
  logic [47:0] subkey;
  logic [4:0]  round_idx;
  logic        subkey_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  des_subkey_sched dut (
    .clk(clk), .rst(rst), .load(load), .key(key), .decrypt(decrypt),
    .step(step), .subkey(subkey), .round_idx(round_idx),
    .subkey_valid(subkey_valid)
  );

  int compress_ref [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  function automatic logic [55:0] m_reduce(input logic [63:0] k);
    logic [55:0] r;
    for (int j = 0; j < 56; j++) begin
      int src;
      if (j < 28)       src = 57 + j / 8 - 8 * (j % 8);
      else if (j < 52)  src = 63 - 8 * ((j - 28) % 8) - (j - 28) / 8;
      else              src = 28 - 8 * (j - 52);
      r[55 - j] = k[64 - src];
    end
    return r;
  endfunction

  function automatic logic [27:0] m_rotl(input logic [27:0] x, input int n);
    logic [27:0] y = x;
    for (int i = 0; i < n % 28; i++) y = {y[26:0], y[27]};
    return y;
  endfunction

  // cumulative shift: two per round minus one for each of the four single-shift rounds
  function automatic int m_cum(input int rr);
    int singles = 0;
    if (rr >= 1)  singles++;
    if (rr >= 2)  singles++;
    if (rr >= 9)  singles++;
    if (rr >= 16) singles++;
    return 2 * rr - singles;
  endfunction

  function automatic logic [47:0] m_subkey(input logic [63:0] k, input bit dec, input int r);
    logic [55:0] base = m_reduce(k);
    logic [55:0] cd;
    logic [47:0] s;
    int rr = dec ? 17 - r : r;
    cd = {m_rotl(base[55:28], m_cum(rr)), m_rotl(base[27:0], m_cum(rr))};
    for (int j = 0; j < 48; j++) s[47 - j] = cd[56 - compress_ref[j]];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] k, input bit dec);
    @(negedge clk);
    load = 1'b1; key = k; decrypt = dec;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  // run a full sequence, checking every round; returns the subkeys seen
  task automatic run_seq(input logic [63:0] k, input bit dec, output logic [47:0] seen [16]);
    do_load(k, dec);
    chk(round_idx == 0 && !subkey_valid, "R2 load rewind", 64'(round_idx), 64'd0);
    for (int r = 1; r <= 16; r++) begin
      logic [47:0] exp;
      do_step();
      exp = m_subkey(k, dec, r);
      seen[r-1] = subkey;
      chk(round_idx == 5'(r) && subkey_valid, "R3 round advance", 64'(round_idx), 64'(r));
      chk(subkey == exp, dec ? "R5 reverse subkey" : "R4 forward subkey", 64'(subkey), 64'(exp));
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] keys [10];
    logic [47:0] enc_s [16];
    logic [47:0] dec_s [16];
    logic [47:0] par_s [16];
    logic [63:0] x;
    logic [47:0] hold;

    rst = 1'b1; load = 1'b0; step = 1'b0; decrypt = 1'b0; key = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(round_idx == 0 && !subkey_valid && subkey == 0, "R1 reset state",
        {15'd0, subkey_valid, round_idx, 43'd0} | 64'(subkey), 64'd0);

    // published anchor subkeys
    do_load(64'h133457799BBCDFF1, 1'b0);
    do_step();
    chk(subkey == 48'h1B02EFFC7072, "R4 known round 1", 64'(subkey), 64'h1B02EFFC7072);
    repeat (15) do_step();
    chk(subkey == 48'hCB3D8B0E17F5, "R4 known round 16", 64'(subkey), 64'hCB3D8B0E17F5);

    // R7: extra steps after the last round
    hold = subkey;
    repeat (3) do_step();
    chk(round_idx == 16 && subkey == hold, "R7 hold after round 16", 64'(subkey), 64'(hold));

    keys[0] = 64'h133457799BBCDFF1;
    keys[1] = 64'h0123456789ABCDEF;
    keys[2] = 64'h0;
    keys[3] = 64'hFFFFFFFFFFFFFFFF;
    keys[4] = 64'hAAAAAAAAAAAAAAAA;
    x = 64'h9E3779B97F4A7C15;
    for (int i = 5; i < 10; i++) begin
      x ^= x << 13; x ^= x >> 7; x ^= x << 17;
      keys[i] = x;
    end

    for (int i = 0; i < 10; i++) begin
      run_seq(keys[i], 1'b0, enc_s);
      run_seq(keys[i], 1'b1, dec_s);
      for (int r = 0; r < 16; r++)
        chk(dec_s[r] == enc_s[15 - r], "R5 reverse of forward", 64'(dec_s[r]), 64'(enc_s[15 - r]));
      // R6: flip only the parity bits
      run_seq(keys[i] ^ 64'h0101010101010101, 1'b0, par_s);
      for (int r = 0; r < 16; r++)
        chk(par_s[r] == enc_s[r], "R6 parity ignored", 64'(par_s[r]), 64'(enc_s[r]));
    end

    // R8: idle cycles hold everything
    do_load(keys[1], 1'b0);
    repeat (4) do_step();
    hold = subkey;
    repeat (5) @(negedge clk);
    chk(subkey == hold && round_idx == 4 && subkey_valid, "R8 idle hold", 64'(subkey), 64'(hold));

    // R10: mode change mid-sequence is ignored
    decrypt = 1'b1;
    do_step();
    chk(subkey == m_subkey(keys[1], 1'b0, 5), "R10 mode latched",
        64'(subkey), 64'(m_subkey(keys[1], 1'b0, 5)));

    // R9: restart in mid-sequence with a different key and order
    do_load(keys[6], 1'b1);
    do_step();
    chk(round_idx == 1 && subkey == m_subkey(keys[6], 1'b1, 1), "R9 restart round 1",
        64'(subkey), 64'(m_subkey(keys[6], 1'b1, 1)));
    do_step();
    chk(subkey == m_subkey(keys[6], 1'b1, 2), "R9 restart round 2",
        64'(subkey), 64'(m_subkey(keys[6], 1'b1, 2)));

    // R2: load and step together, load wins
    @(negedge clk);
    load = 1'b1; step = 1'b1; key = keys[7]; decrypt = 1'b0;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    chk(round_idx == 0 && !subkey_valid, "R2 load beats step", 64'(round_idx), 64'd0);
    do_step();
    chk(subkey == m_subkey(keys[7], 1'b0, 1), "R2 new key round 1",
        64'(subkey), 64'(m_subkey(keys[7], 1'b0, 1)));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule